// File: doc/BRIEF.md
# Layered Register Bridge

This block carries one CPU register access at a time from a fast core-side bus, across an intermediate bus, to a slow register bus. All three buses run from the single core clock. The intermediate and peripheral buses advance only on enable strobes that the block generates itself, so each bus "edge" is a core-clock edge at which its strobe is high. The core divides down to the intermediate bus by 1, 2, 3, 4 or 8. The intermediate bus divides down to the peripheral bus by 1 to 4.

An accepted request first spends three core cycles in preparation. It then waits for the next intermediate edge, which is the hand-off to the intermediate bus. It then waits for the first peripheral edge at least one intermediate period later. The register access itself follows and lasts two peripheral periods. A read spends two more core cycles bringing the data back. The peripheral is a small register file inside the block. It is written or read at the last edge of the access window.

Requests use valid/ready. `req_ready` is high only while the bridge is idle, and a request is taken on an edge where both `req_valid` and `req_ready` are high. Responses also use valid/ready. Once `rsp_valid` is up, it and `rsp_rdata` stay put until an edge where `rsp_ready` is high. No new request is taken until that response has been consumed. The ratio selects are sampled only while the bridge is idle.

Top module: `lrb_bridge`

## Requirements
- R1: While reset is applied and after it is released, `rsp_valid` is low and `req_ready` is high.
- R2: The ratio selects are encoded as follows. `cfg_core_bus_sel` 0,1,2,3,4 gives a core:intermediate ratio B of 1,2,3,4,8, and any other value gives B = 1. `cfg_bus_per_sel` value v gives an intermediate:peripheral ratio P = v+1. `bus_ce_o` pulses once every B core cycles, and `per_ce_o` pulses once every B·P core cycles.
- R3: Count the accepting edge as edge 0. The hand-off to the intermediate bus happens at the first intermediate edge T with T ≥ 3, so the alignment wait n = T−3 lies in 0..B−1.
- R4: A write's response appears after edge P0 + 2·B·P, counted from the accepting edge. P0 is the first peripheral edge after T, so P0 − T = (1+m)·B with m in 0..P−1. The total is therefore (3+n) + (1+m)·B + 2·B·P core cycles.
- R5: A read takes exactly 2 core cycles longer than a write with the same n and m.
- R6: A read returns the value most recently written to the same address. Writes to one address leave all other addresses unchanged. A write's response carries zero data.
- R7: After a request is accepted, `req_ready` stays low until the response has been consumed. Requests presented in that time have no effect.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_rdata` holds its value.
- R9: A change of the ratio selects while an access is in flight changes neither the strobe period nor the latency of that access. The new ratios take effect once the bridge is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_core_bus_sel | input | 3 | Core:intermediate ratio select |
| cfg_bus_per_sel | input | 2 | Intermediate:peripheral ratio select |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Bridge idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| bus_ce_o | output | 1 | Intermediate-bus enable strobe |
| per_ce_o | output | 1 | Peripheral-bus enable strobe |

## Verification
Writes and reads run across all twenty ratio pairs. Each access is measured in core cycles against the latency formula, using the alignment that the bench observes on the strobe ports. This separates errors in the fixed preparation and return phases from errors in the alignment waits.

Strobe counting over a window that every period divides exactly catches a wrong ratio decode. Requests presented while the bridge is busy show whether a second access can slip in. A stalled response shows whether the response is held under back-pressure. A ratio change in the middle of an access shows whether the configuration is sampled too early.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
  localparam int PREP_CYC   = 3;
  localparam int RET_CYC    = 2;
  localparam int PACC_EDGES = 2;
  localparam int BDIV_W     = 4;
  localparam int PDIV_W     = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_SYNC,
    ST_XFER,
    ST_PACC,
    ST_RET,
    ST_RESP
  } lrb_state_e;

  function automatic logic [BDIV_W-1:0] core_bus_div(input logic [2:0] sel);
    logic [BDIV_W-1:0] d;
    case (sel)
      3'd0:    d = BDIV_W'(1);
      3'd1:    d = BDIV_W'(2);
      3'd2:    d = BDIV_W'(3);
      3'd3:    d = BDIV_W'(4);
      3'd4:    d = BDIV_W'(8);
      default: d = BDIV_W'(1);
    endcase
    return d;
  endfunction

  function automatic logic [PDIV_W-1:0] bus_per_div(input logic [1:0] sel);
    return PDIV_W'(sel) + PDIV_W'(1);
  endfunction
endpackage

// File: rtl/lrb_clk_en.sv
module lrb_clk_en
  import lrb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic [2:0] core_sel,
  input  logic [1:0] per_sel,
  output logic       bus_ce,
  output logic       per_ce
);
  localparam logic [BDIV_W-1:0] B_ONE = BDIV_W'(1);
  localparam logic [PDIV_W-1:0] P_ONE = PDIV_W'(1);

  logic [BDIV_W-1:0] bdiv_q, bcnt;
  logic [PDIV_W-1:0] pdiv_q, pcnt;

  // ratios frozen while an access is in flight
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bdiv_q <= B_ONE;
      pdiv_q <= P_ONE;
    end else if (!busy) begin
      bdiv_q <= core_bus_div(core_sel);
      pdiv_q <= bus_per_div(per_sel);
    end
  end

  always_comb begin
    bus_ce = (bcnt >= (bdiv_q - B_ONE));
    per_ce = bus_ce && (pcnt >= (pdiv_q - P_ONE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      pcnt <= '0;
    end else begin
      bcnt <= bus_ce ? '0 : bcnt + B_ONE;
      if (bus_ce) pcnt <= per_ce ? '0 : pcnt + P_ONE;
    end
  end

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ($stable(bdiv_q) && $stable(pdiv_q)));

  assert_bus_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ce && busy && bdiv_q > B_ONE) |=> !bus_ce);
endmodule

// File: rtl/lrb_seq.sv
module lrb_seq
  import lrb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_ce,
  input  logic per_ce,
  input  logic req_valid,
  input  logic req_write,
  input  logic rsp_ready,
  output logic req_ready,
  output logic busy,
  output logic accept,
  output logic access_stb,
  output logic wr_q,
  output logic rsp_valid
);
  localparam int CNT_MAX = (PREP_CYC > PACC_EDGES) ?
                           ((PREP_CYC > RET_CYC) ? PREP_CYC : RET_CYC) :
                           ((PACC_EDGES > RET_CYC) ? PACC_EDGES : RET_CYC);
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

  lrb_state_e state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic prep_last, pacc_last, ret_last;

  always_comb begin
    req_ready  = (state == ST_IDLE);
    busy       = (state != ST_IDLE);
    rsp_valid  = (state == ST_RESP);
    accept     = req_valid && req_ready;
    prep_last  = (cnt == CNT_W'(PREP_CYC - 1));
    pacc_last  = (cnt == CNT_W'(PACC_EDGES - 1));
    ret_last   = (cnt == CNT_W'(RET_CYC - 1));
    access_stb = (state == ST_PACC) && per_ce && pacc_last;
  end

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    unique case (state)
      ST_IDLE: if (accept) begin
        state_n = ST_PREP;
        cnt_n   = '0;
      end
      ST_PREP: begin
        if (prep_last) state_n = bus_ce ? ST_XFER : ST_SYNC;
        else           cnt_n   = cnt + C_ONE;
      end
      ST_SYNC: if (bus_ce) state_n = ST_XFER;
      ST_XFER: if (per_ce) begin
        state_n = ST_PACC;
        cnt_n   = '0;
      end
      ST_PACC: if (per_ce) begin
        if (pacc_last) begin
          state_n = wr_q ? ST_RESP : ST_RET;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt + C_ONE;
        end
      end
      ST_RET: begin
        if (ret_last) state_n = ST_RESP;
        else          cnt_n   = cnt + C_ONE;
      end
      ST_RESP: if (rsp_ready) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      wr_q  <= 1'b0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      if (accept) wr_q <= req_write;
    end
  end

  assert_xfer_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XFER && $past(state) != ST_XFER) |-> $past(bus_ce));

  assert_pacc_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PACC && $past(state) != ST_PACC) |-> $past(per_ce));

  assert_ret_only_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RET) |-> !wr_q);
endmodule

// File: rtl/lrb_regfile.sv
module lrb_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               words[g] <= '0;
      else if (we && addr == ADDR_W'(g))        words[g] <= wdata;
    end
  end

  assign rdata = words[addr];
endmodule

// File: rtl/lrb_bridge.sv
module lrb_bridge
  import lrb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_core_bus_sel,
  input  logic [1:0]        cfg_bus_per_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_ce_o,
  output logic              per_ce_o
);
  logic busy, accept, access_stb, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rf_rdata;

  lrb_clk_en u_ce (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .core_sel (cfg_core_bus_sel),
    .per_sel  (cfg_bus_per_sel),
    .bus_ce   (bus_ce_o),
    .per_ce   (per_ce_o)
  );

  lrb_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ce     (bus_ce_o),
    .per_ce     (per_ce_o),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rsp_ready  (rsp_ready),
    .req_ready  (req_ready),
    .busy       (busy),
    .accept     (accept),
    .access_stb (access_stb),
    .wr_q       (wr_q),
    .rsp_valid  (rsp_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (access_stb) rdata_q <= wr_q ? '0 : rf_rdata;
    end
  end

  lrb_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (access_stb && wr_q),
    .addr  (addr_q),
    .wdata (wdata_q),
    .rdata (rf_rdata)
  );

  assign rsp_rdata = rdata_q;

  assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_ready && !rsp_valid));
endmodule

// File: tb/lrb_bridge_tb.sv
module lrb_bridge_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] cfg_cb;
  logic [1:0] cfg_bp;
  logic req_valid, req_write, rsp_ready;
  logic [3:0] req_addr;
  logic [15:0] req_wdata;
  logic req_ready, rsp_valid, bus_ce_o, per_ce_o;
  logic [15:0] rsp_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] shadow [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  lrb_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_core_bus_sel(cfg_cb), .cfg_bus_per_sel(cfg_bp),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .bus_ce_o(bus_ce_o), .per_ce_o(per_ce_o)
  );

  function automatic int bdiv_of(input logic [2:0] s);
    case (s)
      3'd0: return 1; 3'd1: return 2; 3'd2: return 3;
      3'd3: return 4; 3'd4: return 8; default: return 1;
    endcase
  endfunction

  function automatic int pdiv_of(input logic [1:0] s);
    return int'(s) + 1;
  endfunction

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // one access, measured in core cycles from the accepting edge
  task automatic do_access(input bit wr, input logic [3:0] a, input logic [15:0] d,
                           input bit poke, input bit hold, input bit chg,
                           output logic [15:0] rd);
    int bd, pd, e, t_x, p0, lastb, lat, expl;
    bit gap_bad;
    logic [15:0] rd0;
    repeat (12) @(negedge clk);
    bd = bdiv_of(cfg_cb);
    pd = pdiv_of(cfg_bp);
    check(req_ready == 1'b1, "R7 idle before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    e = 0; t_x = -1; p0 = -1; lastb = -1; lat = -1; gap_bad = 0;
    forever begin
      @(negedge clk);
      if (e == 0) begin
        req_valid = 1'b0;
        if (chg) begin cfg_cb = 3'd0; cfg_bp = 2'd0; end
      end
      if (poke && e == 4) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = ~a; req_wdata = 16'hDEAD;
      end
      if (poke && e >= 4) check(req_ready == 1'b0, "R7 ready low while busy", req_ready, 0);
      if (rsp_valid) begin lat = e; break; end
      if (bus_ce_o) begin
        if (lastb >= 0 && (e + 1 - lastb) != bd) gap_bad = 1;
        lastb = e + 1;
        if (t_x < 0 && e + 1 >= 3) t_x = e + 1;
      end
      if (per_ce_o && t_x >= 0 && e + 1 > t_x && p0 < 0) p0 = e + 1;
      @(posedge clk);
      e++;
      if (e > 2000) break;
    end
    req_valid = 1'b0;
    check(!gap_bad, chg ? "R9 strobe period kept after cfg change" : "R2 strobe period",
          gap_bad, 0);
    check(t_x >= 3 && (t_x - 3) < bd, "R3 alignment wait n", t_x - 3, bd - 1);
    check(p0 > t_x && ((p0 - t_x) % bd) == 0 && ((p0 - t_x) / bd - 1) < pd,
          "R4 peripheral alignment m", p0 - t_x, bd);
    expl = p0 + 2 * bd * pd + (wr ? 0 : 2);
    if (wr) check(lat == expl, chg ? "R9 write latency" : "R4 write latency", lat, expl);
    else    check(lat == expl, chg ? "R9 read latency"  : "R5 read latency",  lat, expl);
    if (hold) begin
      rsp_ready = 1'b0;
      rd0 = rsp_rdata;
      repeat (4) begin
        @(posedge clk); @(negedge clk);
        check(rsp_valid == 1'b1, "R8 valid held", rsp_valid, 1);
        check(rsp_rdata == rd0, "R8 data held", rsp_rdata, rd0);
        check(req_ready == 1'b0, "R7 no accept before consume", req_ready, 0);
      end
      rsp_ready = 1'b1;
    end
    rd = rsp_rdata;
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R7 idle after consume",
          {rsp_valid, req_ready}, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_cb = 3'd0; cfg_bp = 2'd0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R1 during reset", {rsp_valid, req_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    check(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
    for (int i = 0; i < 16; i++) shadow[i] = '0;
  endtask

  task automatic t_strobes(input logic [2:0] cs, input logic [1:0] ps);
    int nb, np, bd, pd;
    cfg_cb = cs; cfg_bp = ps;
    bd = bdiv_of(cs); pd = pdiv_of(ps);
    repeat (40) @(negedge clk);
    nb = 0; np = 0;
    for (int i = 0; i < 288; i++) begin
      if (bus_ce_o) nb++;
      if (per_ce_o) np++;
      @(negedge clk);
    end
    check(nb == 288 / bd, "R2 bus strobe count", nb, 288 / bd);
    check(np == 288 / (bd * pd), "R2 peripheral strobe count", np, 288 / (bd * pd));
  endtask

  task automatic t_sweep();
    logic [15:0] rd, v;
    logic [3:0] a;
    for (int cs = 0; cs < 5; cs++) begin
      for (int ps = 0; ps < 4; ps++) begin
        cfg_cb = 3'(cs); cfg_bp = 2'(ps);
        a = 4'(cs * 4 + ps);
        v = 16'(16'h1357 * (cs * 4 + ps + 1));
        do_access(1'b1, a, v, 1'b0, 1'b0, 1'b0, rd);
        shadow[a] = v;
        check(rd == 16'h0, "R6 write response data zero", rd, 0);
        do_access(1'b0, a, 16'h0, 1'b0, 1'b0, 1'b0, rd);
        check(rd == v, "R6 read returns last write", rd, v);
      end
    end
  endtask

  task automatic t_isolation();
    logic [15:0] rd;
    cfg_cb = 3'd1; cfg_bp = 2'd1;
    for (int i = 0; i < 16; i += 3) begin
      do_access(1'b0, 4'(i), 16'h0, 1'b0, 1'b0, 1'b0, rd);
      check(rd == shadow[i], "R6 other registers untouched", rd, shadow[i]);
    end
  endtask

  task automatic t_busy_ignore();
    logic [15:0] rd;
    cfg_cb = 3'd3; cfg_bp = 2'd2;
    do_access(1'b1, 4'd3, 16'hA5A5, 1'b1, 1'b0, 1'b0, rd);
    shadow[3] = 16'hA5A5;
    do_access(1'b0, 4'd12, 16'h0, 1'b0, 1'b0, 1'b0, rd);
    check(rd == shadow[12], "R7 busy-time request ignored", rd, shadow[12]);
    do_access(1'b0, 4'd3, 16'h0, 1'b0, 1'b0, 1'b0, rd);
    check(rd == 16'hA5A5, "R7 accepted write landed", rd, 16'hA5A5);
  endtask

  task automatic t_backpressure();
    logic [15:0] rd;
    cfg_cb = 3'd2; cfg_bp = 2'd3;
    do_access(1'b0, 4'd3, 16'h0, 1'b0, 1'b1, 1'b0, rd);
    check(rd == 16'hA5A5, "R8 stalled read data", rd, 16'hA5A5);
  endtask

  task automatic t_cfg_frozen();
    logic [15:0] rd;
    int nb;
    cfg_cb = 3'd4; cfg_bp = 2'd3;
    do_access(1'b1, 4'd9, 16'h0F0F, 1'b0, 1'b0, 1'b1, rd);
    shadow[9] = 16'h0F0F;
    repeat (20) @(negedge clk);
    nb = 0;
    for (int i = 0; i < 48; i++) begin
      if (bus_ce_o) nb++;
      @(negedge clk);
    end
    check(nb == 48, "R9 new ratio once idle", nb, 48);
    do_access(1'b0, 4'd9, 16'h0, 1'b0, 1'b0, 1'b0, rd);
    check(rd == 16'h0F0F, "R9 write under frozen ratio", rd, 16'h0F0F);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_strobes(3'd0, 2'd0);
    t_strobes(3'd2, 2'd2);
    t_strobes(3'd4, 2'd3);
    t_strobes(3'd7, 2'd1);
    t_sweep();
    t_isolation();
    t_busy_ignore();
    t_backpressure();
    t_cfg_frozen();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule